// File: doc/BRIEF.md
# Transmit Descriptor Command Sequencer

The sequencer takes transmit descriptors from a fetch unit one at a time. Each descriptor carries an 8-bit command byte, a buffer address, a byte length and a 16-bit tag. The block turns the descriptors into three kinds of output: segment requests for the data mover, per-packet option words for the transmit datapath, and status write-back requests with a ring head-advance strobe. A packet can span several descriptors, and the last one carries the end-of-packet flag. Option bits count only on that last descriptor. The options are latched there and offered to the datapath over a valid/ready handshake. No further descriptor is taken until the datapath accepts them.

Status write-back can be conditional or deferred. An ordinary descriptor gets a descriptor-done write-back only if it asks for one. A final descriptor that asks for a sent-confirmation holds back its write-back and the head-advance strobe until the transmit path reports the packet's result. That result is copied into the status nibble. A descriptor with a zero address or a zero length moves no data, but it is still retired and still reported.

Top module: `txd_cmd_seq`

## Requirements
- R1: After reset, desc_ready is 1 and dp_valid, seg_valid, wb_valid and head_adv are all 0.
- R2: Command bit 0 marks end of packet. The option bits (bit 1 append CRC, bit 2 insert checksum, bit 6 VLAN tag) take effect only on a descriptor with bit 0 set. On other descriptors they are ignored. Bits 5 and 7 have no effect.
- R3: dp_add_vlan is 1 only when command bit 6 and vlan_mode_en are both 1. dp_vlan_word is then {vlan_ethertype, desc_tag}, and dp_add_crc is forced to 1.
- R4: When VLAN insertion is not active, dp_add_crc equals command bit 1 of the end-of-packet descriptor.
- R5: dp_valid rises one cycle after an end-of-packet descriptor is accepted. It stays high, with its option outputs stable, until dp_ready is seen. desc_ready is 0 for that whole time.
- R6: dp_seg_count gives the number of descriptors in the packet, the final one included. It saturates at 2**CNT_W-1.
- R7: seg_valid pulses for one cycle, one cycle after acceptance, and carries the address, length and end-of-packet flag. It does not pulse when the address or the length is zero.
- R8: A descriptor that is not deferred produces head_adv one cycle after acceptance, even when it is empty. It also produces wb_valid if command bit 3 is set. The status is then 4'b0001, where bit 0 is descriptor done, bit 1 is excess collision, bit 2 is late collision and bit 3 is reserved 0.
- R9: A descriptor with bits 4 and 0 both set is deferred. It produces no wb_valid or head_adv, and desc_ready stays 0, until tx_done_valid arrives after the option handshake. One cycle after tx_done_valid, wb_valid and head_adv pulse together. The status is then {1'b0, tx_late_col, tx_excess_col, 1'b1}. tx_done_valid is ignored before the option handshake.
- R10: Command bit 4 on a descriptor without bit 0 is ignored, and that descriptor is retired as in R8. tx_done_valid has no effect while nothing is deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be accepted |
| desc_cmd | input | 8 | Command byte |
| desc_addr | input | ADDR_W | Buffer address |
| desc_len | input | LEN_W | Buffer length in bytes |
| desc_tag | input | TAG_W | Tag field for VLAN insertion |
| vlan_mode_en | input | 1 | Global VLAN insertion enable |
| vlan_ethertype | input | TAG_W | Ethertype inserted with the tag |
| seg_valid | output | 1 | Segment request pulse |
| seg_addr | output | ADDR_W | Segment address |
| seg_len | output | LEN_W | Segment length |
| seg_last | output | 1 | Segment ends the packet |
| dp_valid | output | 1 | Packet options offered |
| dp_ready | input | 1 | Datapath accepts options |
| dp_add_crc | output | 1 | Append CRC |
| dp_add_csum | output | 1 | Insert checksum |
| dp_add_vlan | output | 1 | Insert VLAN tag |
| dp_vlan_word | output | 2*TAG_W | Ethertype and tag to insert |
| dp_seg_count | output | CNT_W | Descriptors in this packet |
| tx_done_valid | input | 1 | Packet sent or failed |
| tx_excess_col | input | 1 | Packet failed on excess collisions |
| tx_late_col | input | 1 | Packet saw a late collision |
| wb_valid | output | 1 | Status write-back request pulse |
| wb_status | output | 4 | Status nibble |
| head_adv | output | 1 | Ring head advance pulse |

## Verification
If the deferral state were wrong, it would show within one cycle of a tx_done_valid strobe or of the next descriptor offer. The symptom is a head_adv or wb_valid pulse with no cause, or desc_ready staying low after the datapath has taken the packet options. A stale option latch or segment counter would show on dp_add_* or dp_seg_count in the first cycle of dp_valid for the next packet. The bench therefore samples each of these outputs one cycle after the edge that should change them, using the bit positions and field layouts fixed in R2, R8 and R9.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int CMD_EOP  = 0;
   localparam int CMD_CRC  = 1;
   localparam int CMD_CSUM = 2;
   localparam int CMD_RPT  = 3;
   localparam int CMD_SENT = 4;
   localparam int CMD_EXT  = 5;
   localparam int CMD_VLAN = 6;
   localparam int CMD_IDLY = 7;

   localparam int ST_DONE  = 0;
   localparam int ST_EXCOL = 1;
   localparam int ST_LTCOL = 2;

   typedef struct packed {
      logic crc;
      logic csum;
      logic vlan;
   } pkt_opts_t;
endpackage

// File: rtl/txd_cmd_decode.sv
module txd_cmd_decode
   import txd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic [7:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic              vlan_mode_en,
   output logic              eop,
   output logic              report,
   output logic              defer,
   output logic              empty,
   output pkt_opts_t         opts
);
   logic unused_cmd_bits;
   assign unused_cmd_bits = cmd[CMD_EXT] ^ cmd[CMD_IDLY];

   always_comb begin
      eop       = cmd[CMD_EOP];
      report    = cmd[CMD_RPT];
      defer     = cmd[CMD_EOP] & cmd[CMD_SENT];
      empty     = (addr == '0) || (len == '0);
      opts.vlan = cmd[CMD_EOP] & cmd[CMD_VLAN] & vlan_mode_en;
      opts.crc  = cmd[CMD_EOP] & (cmd[CMD_CRC] | opts.vlan);
      opts.csum = cmd[CMD_EOP] & cmd[CMD_CSUM];
   end
endmodule

// File: rtl/txd_pkt_track.sv
module txd_pkt_track
   import txd_pkg::*;
#(
   parameter int CNT_W     = 4,
   parameter int TAG_W     = 16,
   parameter bit SAT_COUNT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic               eop,
   input  pkt_opts_t          opts_in,
   input  logic [TAG_W-1:0]   tag,
   input  logic [TAG_W-1:0]   ethertype,
   input  logic               dp_ready,
   output logic               dp_valid,
   output pkt_opts_t          dp_opts,
   output logic [2*TAG_W-1:0] dp_vlan_word,
   output logic [CNT_W-1:0]   dp_seg_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] seg_cnt;
   logic [CNT_W-1:0] cnt_inc;

   generate
      if (SAT_COUNT) begin : g_sat
         assign cnt_inc = (seg_cnt == CNT_MAX) ? CNT_MAX : seg_cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = seg_cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_cnt      <= '0;
         dp_valid     <= 1'b0;
         dp_opts      <= '0;
         dp_vlan_word <= '0;
         dp_seg_count <= '0;
      end else begin
         if (dp_valid && dp_ready) dp_valid <= 1'b0;
         if (accept) begin
            if (eop) begin
               seg_cnt      <= '0;
               dp_valid     <= 1'b1;
               dp_opts      <= opts_in;
               dp_vlan_word <= opts_in.vlan ? {ethertype, tag} : '0;
               dp_seg_count <= cnt_inc;
            end else begin
               seg_cnt <= cnt_inc;
            end
         end
      end
   end

   AST_OPTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid && !dp_ready |=> dp_valid && $stable(dp_opts) && $stable(dp_seg_count)); // R5
   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid |-> !accept); // R5
endmodule

// File: rtl/txd_wb_ctrl.sv
module txd_wb_ctrl
   import txd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic       report,
   input  logic       defer,
   input  logic       pkt_busy,
   input  logic       tx_done_valid,
   input  logic       tx_excess_col,
   input  logic       tx_late_col,
   output logic       wb_valid,
   output logic [3:0] wb_status,
   output logic       head_adv,
   output logic       wait_sent
);
   logic sent_ok;
   assign sent_ok = wait_sent && !pkt_busy && tx_done_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid  <= 1'b0;
         wb_status <= '0;
         head_adv  <= 1'b0;
         wait_sent <= 1'b0;
      end else begin
         wb_valid <= 1'b0;
         head_adv <= 1'b0;
         if (accept && !defer) begin
            wb_valid  <= report;
            wb_status <= 4'b0001;
            head_adv  <= 1'b1;
         end else if (accept) begin
            wait_sent <= 1'b1;
         end else if (sent_ok) begin
            wait_sent                <= 1'b0;
            wb_valid                 <= 1'b1;
            wb_status                <= '0;
            wb_status[ST_DONE]       <= 1'b1;
            wb_status[ST_EXCOL]      <= tx_excess_col;
            wb_status[ST_LTCOL]      <= tx_late_col;
         end
         if (sent_ok) head_adv <= 1'b1;
      end
   end

   AST_HOLD_RING: assert property (@(posedge clk) disable iff (!rst_n)
      wait_sent |-> !accept); // R9
   AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> wb_status[ST_DONE]); // R8
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !wb_status[3]); // R8
   AST_WB_WITH_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> head_adv); // R8
endmodule

// File: rtl/txd_cmd_seq.sv
module txd_cmd_seq
   import txd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int TAG_W     = 16,
   parameter int CNT_W     = 4,
   parameter bit SAT_COUNT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               desc_valid,
   output logic               desc_ready,
   input  logic [7:0]         desc_cmd,
   input  logic [ADDR_W-1:0]  desc_addr,
   input  logic [LEN_W-1:0]   desc_len,
   input  logic [TAG_W-1:0]   desc_tag,
   input  logic               vlan_mode_en,
   input  logic [TAG_W-1:0]   vlan_ethertype,
   output logic               seg_valid,
   output logic [ADDR_W-1:0]  seg_addr,
   output logic [LEN_W-1:0]   seg_len,
   output logic               seg_last,
   output logic               dp_valid,
   input  logic               dp_ready,
   output logic               dp_add_crc,
   output logic               dp_add_csum,
   output logic               dp_add_vlan,
   output logic [2*TAG_W-1:0] dp_vlan_word,
   output logic [CNT_W-1:0]   dp_seg_count,
   input  logic               tx_done_valid,
   input  logic               tx_excess_col,
   input  logic               tx_late_col,
   output logic               wb_valid,
   output logic [3:0]         wb_status,
   output logic               head_adv
);
   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic      d_eop, d_report, d_defer, d_empty;
   pkt_opts_t d_opts, q_opts;
   logic      accept, wait_sent;

   assign desc_ready = !dp_valid && !wait_sent;
   assign accept     = desc_valid && desc_ready;

   txd_cmd_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
      .cmd(desc_cmd), .addr(desc_addr), .len(desc_len), .vlan_mode_en(vlan_mode_en),
      .eop(d_eop), .report(d_report), .defer(d_defer), .empty(d_empty), .opts(d_opts)
   );

   txd_pkt_track #(.CNT_W(CNT_W), .TAG_W(TAG_W), .SAT_COUNT(SAT_COUNT)) u_pkt (
      .clk(clk), .rst_n(rst_n), .accept(accept), .eop(d_eop), .opts_in(d_opts),
      .tag(desc_tag), .ethertype(vlan_ethertype), .dp_ready(dp_ready),
      .dp_valid(dp_valid), .dp_opts(q_opts), .dp_vlan_word(dp_vlan_word),
      .dp_seg_count(dp_seg_count)
   );

   txd_wb_ctrl u_wb (
      .clk(clk), .rst_n(rst_n), .accept(accept), .report(d_report), .defer(d_defer),
      .pkt_busy(dp_valid), .tx_done_valid(tx_done_valid), .tx_excess_col(tx_excess_col),
      .tx_late_col(tx_late_col), .wb_valid(wb_valid), .wb_status(wb_status),
      .head_adv(head_adv), .wait_sent(wait_sent)
   );

   assign dp_add_crc  = q_opts.crc;
   assign dp_add_csum = q_opts.csum;
   assign dp_add_vlan = q_opts.vlan;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_valid <= 1'b0;
         seg_addr  <= '0;
         seg_len   <= '0;
         seg_last  <= 1'b0;
      end else begin
         seg_valid <= accept && !d_empty;
         if (accept) begin
            seg_addr <= desc_addr;
            seg_len  <= desc_len;
            seg_last <= d_eop;
         end
      end
   end

   AST_SEG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_addr != '0) && (seg_len != '0)); // R7
   AST_VLAN_FORCES_CRC: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid && dp_add_vlan |-> dp_add_crc); // R3
   AST_READY_LOW_OPTS: assert property (@(posedge clk) disable iff (!rst_n)
      dp_valid |-> !desc_ready); // R5
   AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      head_adv |=> !head_adv); // R8
endmodule

// File: tb/tb_txd_cmd_seq.sv
module tb_txd_cmd_seq;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;
   localparam int TAG_W  = 16;
   localparam int CNT_W  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic desc_valid = 1'b0;
   logic desc_ready;
   logic [7:0] desc_cmd = '0;
   logic [ADDR_W-1:0] desc_addr = '0;
   logic [LEN_W-1:0] desc_len = '0;
   logic [TAG_W-1:0] desc_tag = '0;
   logic vlan_mode_en = 1'b0;
   logic [TAG_W-1:0] vlan_ethertype = 16'h8100;
   logic seg_valid, seg_last;
   logic [ADDR_W-1:0] seg_addr;
   logic [LEN_W-1:0] seg_len;
   logic dp_valid, dp_add_crc, dp_add_csum, dp_add_vlan;
   logic dp_ready = 1'b0;
   logic [2*TAG_W-1:0] dp_vlan_word;
   logic [CNT_W-1:0] dp_seg_count;
   logic tx_done_valid = 1'b0, tx_excess_col = 1'b0, tx_late_col = 1'b0;
   logic wb_valid, head_adv;
   logic [3:0] wb_status;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   txd_cmd_seq dut (
      .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_cmd(desc_cmd), .desc_addr(desc_addr), .desc_len(desc_len), .desc_tag(desc_tag),
      .vlan_mode_en(vlan_mode_en), .vlan_ethertype(vlan_ethertype),
      .seg_valid(seg_valid), .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
      .dp_valid(dp_valid), .dp_ready(dp_ready), .dp_add_crc(dp_add_crc),
      .dp_add_csum(dp_add_csum), .dp_add_vlan(dp_add_vlan), .dp_vlan_word(dp_vlan_word),
      .dp_seg_count(dp_seg_count), .tx_done_valid(tx_done_valid),
      .tx_excess_col(tx_excess_col), .tx_late_col(tx_late_col),
      .wb_valid(wb_valid), .wb_status(wb_status), .head_adv(head_adv)
   );

   // {cmd, vlan_mode, exp_crc, exp_csum, exp_vlan, exp_wb}
   localparam logic [12:0] VEC [0:7] = '{
      {8'h01, 1'b0, 4'b0000},
      {8'h03, 1'b0, 4'b1000},
      {8'h05, 1'b0, 4'b0100},
      {8'h41, 1'b1, 4'b1010},
      {8'h41, 1'b0, 4'b0000},
      {8'h09, 1'b0, 4'b0001},
      {8'h4F, 1'b1, 4'b1111},
      {8'hA1, 1'b0, 4'b0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] cmd, input logic [31:0] addr,
                       input logic [15:0] len, input logic [15:0] tag);
      @(negedge clk);
      desc_cmd = cmd; desc_addr = addr; desc_len = len; desc_tag = tag;
      desc_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      desc_valid = 1'b0;
   endtask

   task automatic take_opts();
      dp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      dp_ready = 1'b0;
   endtask

   task automatic tx_result(input logic exc, input logic late);
      tx_done_valid = 1'b1; tx_excess_col = exc; tx_late_col = late;
      @(posedge clk);
      @(negedge clk);
      tx_done_valid = 1'b0; tx_excess_col = 1'b0; tx_late_col = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 desc_ready", desc_ready, 1);
      chk("R1 dp_valid", dp_valid, 0);
      chk("R1 seg_valid", seg_valid, 0);
      chk("R1 wb_valid", wb_valid, 0);
      chk("R1 head_adv", head_adv, 0);

      // table walk: single-descriptor packets
      foreach (VEC[i]) begin
         vlan_mode_en = VEC[i][4];
         send(VEC[i][12:5], 32'h1000 + i, 16'd64, 16'hABCD);
         chk("R5 dp_valid", dp_valid, 1);
         chk("R4 crc", dp_add_crc, VEC[i][3]);
         chk("R2 csum", dp_add_csum, VEC[i][2]);
         chk("R3 vlan", dp_add_vlan, VEC[i][1]);
         chk("R3 vlan word", dp_vlan_word, VEC[i][1] ? 32'h8100ABCD : 32'h0);
         chk("R8 wb_valid", wb_valid, VEC[i][0]);
         chk("R8 head_adv", head_adv, 1);
         chk("R7 seg_valid", seg_valid, 1);
         chk("R7 seg_last", seg_last, 1);
         chk("R7 seg_addr", seg_addr, 32'h1000 + i);
         chk("R6 count", dp_seg_count, 1);
         take_opts();
         chk("R5 released", desc_ready, 1);
      end

      // R2: options on a non-final descriptor are ignored
      vlan_mode_en = 1'b1;
      send(8'h4E, 32'h2000, 16'd10, 16'h1111);
      chk("R2 no opts mid", dp_valid, 0);
      chk("R8 mid wb", wb_valid, 1);
      chk("R8 mid status", wb_status, 4'b0001);
      chk("R7 mid last", seg_last, 0);
      send(8'h01, 32'h2100, 16'd20, 16'h2222);
      chk("R2 crc ignored", dp_add_crc, 0);
      chk("R2 csum ignored", dp_add_csum, 0);
      chk("R2 vlan ignored", dp_add_vlan, 0);
      chk("R6 two segs", dp_seg_count, 2);
      // R5: hold with dp_ready low
      repeat (3) @(negedge clk);
      chk("R5 held valid", dp_valid, 1);
      chk("R5 ready low", desc_ready, 0);
      chk("R5 held count", dp_seg_count, 2);
      take_opts();

      // R7/R8: empty descriptors
      send(8'h08, 32'h0, 16'd5, 16'h0);
      chk("R7 zero addr", seg_valid, 0);
      chk("R8 empty wb", wb_valid, 1);
      chk("R8 empty head", head_adv, 1);
      send(8'h09, 32'h3000, 16'd0, 16'h0);
      chk("R7 zero len", seg_valid, 0);
      chk("R8 empty eop wb", wb_valid, 1);
      take_opts();

      // R9: deferred write-back
      send(8'h11, 32'h4000, 16'd100, 16'h0);
      chk("R9 no wb at accept", wb_valid, 0);
      chk("R9 no head at accept", head_adv, 0);
      tx_result(1'b1, 1'b0);
      chk("R9 early tx ignored", wb_valid, 0);
      take_opts();
      repeat (2) @(negedge clk);
      chk("R9 ready held", desc_ready, 0);
      chk("R9 head held", head_adv, 0);
      tx_result(1'b1, 1'b0);
      chk("R9 wb after sent", wb_valid, 1);
      chk("R9 status excess", wb_status, 4'b0011);
      chk("R9 head after sent", head_adv, 1);
      chk("R9 ready back", desc_ready, 1);
      send(8'h19, 32'h4100, 16'd100, 16'h0);
      take_opts();
      tx_result(1'b0, 1'b1);
      chk("R9 status late", wb_status, 4'b0101);
      chk("R9 wb late", wb_valid, 1);

      // R10: sent-confirmation bit without end of packet
      send(8'h10, 32'h5000, 16'd8, 16'h0);
      chk("R10 mid not deferred head", head_adv, 1);
      chk("R10 mid no wb", wb_valid, 0);
      chk("R10 ready", desc_ready, 1);
      tx_result(1'b1, 1'b1);
      chk("R10 stray tx wb", wb_valid, 0);
      chk("R10 stray tx head", head_adv, 0);
      send(8'h01, 32'h5100, 16'd8, 16'h0);
      take_opts();

      // R6: saturation at 15
      for (int k = 0; k < 17; k++) send(8'h00, 32'h6000, 16'd4, 16'h0);
      send(8'h01, 32'h6000, 16'd4, 16'h0);
      chk("R6 saturate", dp_seg_count, 15);
      take_opts();

      finish_run();
   end
endmodule